// File: doc/BRIEF.md
# Extended Address and Chip-Select Generator

This block widens the external address of an 8-bit controller to a 1 MB program and data space. It sits beside the core's bus unit. The core reports, on a sideband input, what kind of external transfer the current cycle carries. The block then produces the high address byte and four upper address lines for that transfer.

Two registers on a small register bus steer the block. The extension control register holds a 4-bit bank number and a mode bit. In bank mode the four upper lines carry the bank number, but only for table reads and for external data transfers addressed by the data pointer. For every other cycle they carry zero. In select mode the same four lines become active-low peripheral selects: exactly one of them is low, chosen by the top two bits of the outgoing high address byte. The page register supplies the high address byte for external data transfers that are addressed through a working register. For every other cycle the core's own high byte passes through.

Both outputs are registered. Each one reflects the transfer class, the address input and the register contents that were sampled at the previous rising clock edge.

Top module: `xaddr_cs_gen`

## Requirements
- R1: While reset is active and in the first cycle after it, `upper_out` is 4'h0 and `addr_hi_out` is 8'h00, and both registers read back 8'h00.
- R2: A write with `reg_wr_en` high stores all eight bits of `reg_wdata`. It goes to the extension control register when `reg_addr` is 8'hA1 and to the page register when it is 8'hA2. The stored value appears on `reg_rdata` (combinational read by `reg_addr`) from the cycle after the write edge. In the control register, bit 7 is the mode (0 bank, 1 select) and bits 3:0 are the bank number. Bits 6:4 are stored but steer nothing.
- R3: A write to any other address changes neither register, and a read of any other address returns 8'h00.
- R4: In bank mode, a cycle with `xfer_class` = 2'b01 (table read) yields `upper_out` equal to the bank number one clock later.
- R5: In bank mode, a cycle with `xfer_class` = 2'b10 (external data transfer by data pointer) yields `upper_out` equal to the bank number one clock later.
- R6: In bank mode, a cycle with `xfer_class` = 2'b00 (no extended transfer) or 2'b11 (external data transfer by working register) yields `upper_out` = 4'h0 one clock later. The bank value therefore drops to zero on the cycle after the class flag ends.
- R7: In select mode, `upper_out` has exactly one bit low. That bit is the one indexed by `addr_hi_out[7:6]`: 00 lowers bit 0, 01 bit 1, 10 bit 2 and 11 bit 3. This holds whatever the transfer class.
- R8: A cycle with `xfer_class` = 2'b11 yields `addr_hi_out` equal to the page register one clock later. Any other class yields `addr_hi_out` equal to `addr_hi_in` one clock later.
- R9: A register write changes the outputs no earlier than the second rising edge after the write is driven. The write edge itself stores the value, and the next edge uses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| xfer_class | input | 2 | Transfer class of the current cycle (00 none, 01 table read, 10 pointer data, 11 register-indirect data) |
| addr_hi_in | input | 8 | High address byte from the core |
| addr_hi_out | output | 8 | High address byte driven to memory |
| upper_out | output | 4 | Address bits 19:16 or active-low selects |

## Verification
The assertions check the output relations on every cycle:
- in select mode exactly one line is low, and it is the line that matches the high byte;
- in bank mode the lines are zero outside the two bank-carrying classes;
- the source of the high byte follows the transfer class;
- a control write lands in the register.

Only the bench scenarios can show the full picture. These cover the exact bank value for each class, the mapping of all four select codes, the page path, writes to unmapped addresses being ignored, and the two-edge delay from a register write to the outputs.

// File: rtl/xa_pkg.sv
package xa_pkg;

    typedef enum logic [1:0] {
        XF_NONE  = 2'b00,
        XF_TABLE = 2'b01,
        XF_DPTR  = 2'b10,
        XF_RIND  = 2'b11
    } xfer_e;

    localparam logic [7:0] CTRL_ADDR_DEF = 8'hA1;
    localparam logic [7:0] PAGE_ADDR_DEF = 8'hA2;

endpackage

// File: rtl/xa_regs.sv
module xa_regs #(
    parameter int          DW        = 8,
    parameter int          BANK_W    = 4,
    parameter logic [7:0]  CTRL_ADDR = 8'hA1,
    parameter logic [7:0]  PAGE_ADDR = 8'hA2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              sel_mode,
    output logic [BANK_W-1:0] bank,
    output logic [DW-1:0]     page
);

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [DW-1:0] page;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && addr == CTRL_ADDR) st_d.ctrl = wdata;
        if (wr_en && addr == PAGE_ADDR) st_d.page = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (addr == CTRL_ADDR)      rdata = st_q.ctrl;
        else if (addr == PAGE_ADDR) rdata = st_q.page;
        else                        rdata = '0;
    end

    assign sel_mode = st_q.ctrl[DW-1];
    assign bank     = st_q.ctrl[BANK_W-1:0];
    assign page     = st_q.page;

    // R2: a control write lands in the register
    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr == CTRL_ADDR) |-> (sel_mode == $past(wdata[DW-1])
                                               && bank == $past(wdata[BANK_W-1:0])));

    // R3: writes elsewhere leave the page register untouched
    a_r3_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!(wr_en && addr == PAGE_ADDR)) |-> $stable(page));

endmodule

// File: rtl/xa_cs_decode.sv
module xa_cs_decode #(
    parameter int SEL_W = 2,
    localparam int LINES = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    output logic [LINES-1:0] cs_n
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign cs_n[i] = (sel != SEL_W'(i));
    end

endmodule

// File: rtl/xa_upper_sel.sv
module xa_upper_sel #(
    parameter int W = 4
) (
    input  logic          sel_mode,
    input  xa_pkg::xfer_e xclass,
    input  logic [W-1:0]  bank,
    input  logic [W-1:0]  cs_n,
    output logic [W-1:0]  upper
);

    import xa_pkg::*;

    logic carries_bank;

    always_comb begin
        carries_bank = (xclass == XF_TABLE) || (xclass == XF_DPTR);
        if (sel_mode)          upper = cs_n;
        else if (carries_bank) upper = bank;
        else                   upper = '0;
    end

endmodule

// File: rtl/xaddr_cs_gen.sv
module xaddr_cs_gen #(
    parameter int         DW        = 8,
    parameter int         SEL_W     = 2,
    parameter logic [7:0] CTRL_ADDR = xa_pkg::CTRL_ADDR_DEF,
    parameter logic [7:0] PAGE_ADDR = xa_pkg::PAGE_ADDR_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [7:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [1:0]    xfer_class,
    input  logic [DW-1:0] addr_hi_in,
    output logic [DW-1:0] addr_hi_out,
    output logic [3:0]    upper_out
);

    import xa_pkg::*;

    localparam int LINES = 1 << SEL_W;

    typedef struct packed {
        logic [LINES-1:0] upper;
        logic [DW-1:0]    hi;
    } out_t;

    out_t          o_d, o_q;
    logic          sel_mode;
    logic [LINES-1:0] bank;
    logic [DW-1:0] page;
    logic [LINES-1:0] cs_n;
    logic [LINES-1:0] upper_nx;
    xfer_e         xclass;

    assign xclass = xfer_e'(xfer_class);

    xa_regs #(
        .DW(DW), .BANK_W(LINES), .CTRL_ADDR(CTRL_ADDR), .PAGE_ADDR(PAGE_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .sel_mode(sel_mode),
        .bank(bank), .page(page)
    );

    xa_cs_decode #(.SEL_W(SEL_W)) u_dec (
        .sel(o_d.hi[DW-1 -: SEL_W]), .cs_n(cs_n)
    );

    xa_upper_sel #(.W(LINES)) u_sel (
        .sel_mode(sel_mode), .xclass(xclass), .bank(bank),
        .cs_n(cs_n), .upper(upper_nx)
    );

    always_comb begin
        o_d.hi    = (xclass == XF_RIND) ? page : addr_hi_in;
        o_d.upper = upper_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign addr_hi_out = o_q.hi;
    assign upper_out   = o_q.upper;

    // R7: select mode leaves exactly one line low
    a_r7_one_low: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel_mode) |-> $countones(~upper_out) == 1);

    // R7: the low line matches the outgoing high byte
    a_r7_line_match: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel_mode) |-> upper_out[addr_hi_out[DW-1 -: SEL_W]] == 1'b0);

    // R6: bank mode gives zero outside the bank-carrying classes
    a_r6_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!sel_mode && (xfer_class == 2'b00 || xfer_class == 2'b11))
        |-> upper_out == '0);

    // R8: register-indirect transfers take the page byte
    a_r8_page_src: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xfer_class == 2'b11) |-> addr_hi_out == $past(page));

    // R8: other transfers pass the core's byte through
    a_r8_pass_src: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xfer_class != 2'b11) |-> addr_hi_out == $past(addr_hi_in));

endmodule

// File: tb/xaddr_cs_gen_bench.sv
module xaddr_cs_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [1:0] xfer_class = 2'b00;
    logic [7:0] addr_hi_in = 8'h00;
    logic [7:0] addr_hi_out;
    logic [3:0] upper_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_ctrl = 8'h00;
    logic [7:0] m_page = 8'h00;

    always #4 clk = ~clk;

    xaddr_cs_gen u_xaddr_cs_gen (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_class(xfer_class),
        .addr_hi_in(addr_hi_in), .addr_hi_out(addr_hi_out), .upper_out(upper_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_upper(input logic [1:0] cls, input logic [7:0] hi);
        if (m_ctrl[7]) return ~(4'b0001 << hi[7:6]);
        if (cls == 2'b01 || cls == 2'b10) return m_ctrl[3:0];
        return 4'h0;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (a == 8'hA1) m_ctrl = d;
        if (a == 8'hA2) m_page = d;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    // drive one cycle of a transfer and check the registered outputs
    task automatic xfer(input string req, input logic [1:0] cls, input logic [7:0] hi);
        logic [7:0] ehi;
        xfer_class = cls; addr_hi_in = hi;
        ehi = (cls == 2'b11) ? m_page : hi;
        @(negedge clk);
        check({req, " hi"}, addr_hi_out, ehi);
        check({req, " upper"}, {4'h0, upper_out}, {4'h0, exp_upper(cls, ehi)});
    endtask

    task automatic t_reset();
        check("R1 upper", {4'h0, upper_out}, 8'h00);
        check("R1 hi", addr_hi_out, 8'h00);
        rd("R1 ctrl", 8'hA1, 8'h00);
        rd("R1 page", 8'hA2, 8'h00);
    endtask

    task automatic t_regs();
        wr(8'hA1, 8'h5C);
        rd("R2 ctrl", 8'hA1, 8'h5C);
        wr(8'hA2, 8'h3E);
        rd("R2 page", 8'hA2, 8'h3E);
        wr(8'h7F, 8'hFF);
        wr(8'hA0, 8'hFF);
        rd("R3 ctrl kept", 8'hA1, 8'h5C);
        rd("R3 page kept", 8'hA2, 8'h3E);
        rd("R3 unmapped read", 8'h7F, 8'h00);
        xfer("R3 outputs after stray write", 2'b01, 8'h12);
    endtask

    task automatic t_bank();
        wr(8'hA1, 8'h0B);
        xfer("R4 table read", 2'b01, 8'hC4);
        xfer("R5 pointer data", 2'b10, 8'h80);
        xfer("R6 flag ended", 2'b00, 8'h80);
        xfer("R6 indirect", 2'b11, 8'h55);
        xfer("R8 pass", 2'b00, 8'hA7);
        wr(8'hA1, 8'h06);
        xfer("R5 new bank", 2'b10, 8'h01);
    endtask

    task automatic t_select();
        wr(8'hA1, 8'h83);
        for (int k = 0; k < 4; k++) begin
            xfer("R7 decode", 2'(k), 8'((k << 6) | 8'h15));
        end
        wr(8'hA2, 8'hC0);
        xfer("R7 page code", 2'b11, 8'h00);
        wr(8'hA2, 8'h40);
        xfer("R8 page", 2'b11, 8'hFF);
    endtask

    task automatic t_latency();
        wr(8'hA1, 8'h09);
        xfer_class = 2'b01; addr_hi_in = 8'h00;
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 8'hA1; reg_wdata = 8'h02;
        @(negedge clk);
        reg_wr_en = 1'b0;
        check("R9 old bank at write edge", {4'h0, upper_out}, 8'h09);
        m_ctrl = 8'h02;
        @(negedge clk);
        check("R9 new bank next edge", {4'h0, upper_out}, 8'h02);
        xfer_class = 2'b00;
        @(negedge clk);
        check("R6 zero after flag", {4'h0, upper_out}, 8'h00);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {4'h0, upper_out}, 8'h00);
        t_regs();
        t_bank();
        t_select();
        t_latency();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule